// File: doc/BRIEF.md
# Quad SPI Master with Timed Select

This block is a synchronous serial master. It drives a serial clock, an active-low select and four data lines that can each be driven or released. A byte is moved most-significant bit first. In single-line mode it travels on one output line and one input line. In quad mode it travels on four lines at once, either outgoing or incoming. Data is presented before the first edge of each bit period and captured on that edge (clock phase 0). The clock polarity is selectable.

Every transfer is framed by three timed windows, all counted in half serial-clock periods:
- a setup window, from select falling to the first clock edge;
- a hold window, from the last clock edge to select rising;
- an idle gap, from select rising until the next byte may be accepted.

The serial clock half-period comes from an even divisor of the reference clock. The host writes bytes through a valid/ready handshake. It receives each incoming byte as a one-cycle pulse at the moment select is released. Configuration inputs are static and may only change while `tx_ready` is high.

Top module: `qspi_timed_master`

## Requirements
- R1: After reset `ss_n`=1, `sclk` equals `cfg_cpol`, `io_oe`=0, `tx_ready`=1 and `rx_valid`=0.
- R2: Each serial-clock half-period lasts h = floor(`cfg_div`/2) reference cycles, with h forced to 1 when `cfg_div` is 0 or 1. The divisor's LSB is ignored, so an odd divisor acts as the even value below it.
- R3: From the cycle `ss_n` falls to the first clock edge is (L+3)·h cycles, where L = `cfg_lead`, and values above 14 act as 14. The setup window therefore spans 1.5 to 8.5 serial-clock periods in half-period steps.
- R4: From the last clock edge to `ss_n` rising is 2·(`cfg_lag`+1)·h cycles.
- R5: After `ss_n` rises, `tx_ready` stays low for 2·(`cfg_gap`+1)·h cycles and then goes high. A byte offered with `tx_valid` while `tx_ready` is high is accepted on that clock edge, and `ss_n` falls in the next cycle.
- R6: `sclk` sits at `cfg_cpol` whenever `ss_n` is high and throughout the setup and hold windows. During the data phase it toggles to the opposite level at each leading edge and returns at each trailing edge.
- R7: The first data bits appear on the outputs in the same cycle `ss_n` falls. The outputs advance at each trailing edge, and the inputs are captured at each leading edge.
- R8: In single mode (`cfg_quad`=0) each byte takes 8 clock periods. Data is sent MSB first on `io_out[0]` with `io_oe`=4'b0001, and captured from `io_in[1]`.
- R9: In quad mode with `cfg_qread`=0, each byte takes 2 clock periods. Bits [7:4] go out on `io_out[3:0]` first, then bits [3:0], with `io_oe`=4'b1111.
- R10: In quad mode with `cfg_qread`=1, `io_oe` stays 0 and the byte is captured from `io_in[3:0]`, high nibble first. `io_oe` is 0 whenever `ss_n` is high.
- R11: `rx_valid` is high for exactly one cycle: the cycle in which `ss_n` rises. In that cycle `rx_data` holds the captured byte.
- R12: `tx_valid` has no effect while `tx_ready` is low. `ss_n` stays high and no extra transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 12 | Serial-clock period in reference cycles (even, 2..4080) |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_quad | input | 1 | 1 = four data lanes |
| cfg_qread | input | 1 | In quad mode, 1 = lanes are inputs |
| cfg_lead | input | 4 | Setup window code, (code+3) half-periods |
| cfg_lag | input | 3 | Hold window code, (code+1) periods |
| cfg_gap | input | 3 | Idle gap code, (code+1) periods |
| tx_valid | input | 1 | Host offers a byte |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block can accept a byte |
| rx_valid | output | 1 | One-cycle pulse, received byte available |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low select |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
Every pin is compared each cycle against a timing model, so state errors surface at the ports quickly:
- A wrong delay counter moves a select or clock edge by at least one reference cycle. It is caught in the first transfer that uses that window.
- A wrong half-period count stretches the very first clock pulse.
- A bad bit counter shows up one period later, as an extra or missing clock pulse before the hold window.
- A wrong shift or capture order corrupts the outgoing lanes within one period, and corrupts `rx_data` at the end of the same byte.

// File: rtl/qspi_timed_master.sv
module qspi_timed_master #(
  parameter int DIV_W    = 12,
  parameter int LEAD_W   = 4,
  parameter int WIN_W    = 3,
  parameter int LEAD_MAX = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_quad,
  input  logic             cfg_qread,
  input  logic [LEAD_W-1:0] cfg_lead,
  input  logic [WIN_W-1:0] cfg_lag,
  input  logic [WIN_W-1:0] cfg_gap,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             sclk,
  output logic             ss_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  localparam int HW   = DIV_W - 1;
  localparam int WMAX = 2 ** (WIN_W + 1);
  localparam int DMAX = (LEAD_MAX + 3 > WMAX) ? LEAD_MAX + 3 : WMAX;
  localparam int DW   = $clog2(DMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_LAG, S_GAP} st_t;

  st_t          st;
  logic [HW-1:0] pcnt;
  logic [DW-1:0] dcnt;
  logic [2:0]   bcnt;
  logic         act;
  logic [7:0]   sh;
  logic [7:0]   rx;

  wire [HW-1:0]     half  = (cfg_div[DIV_W-1:1] == '0) ? HW'(1) : cfg_div[DIV_W-1:1];
  wire              tick  = (pcnt == half - HW'(1));
  wire [LEAD_W-1:0] lsel  = (cfg_lead > LEAD_W'(LEAD_MAX)) ? LEAD_W'(LEAD_MAX) : cfg_lead;
  wire [DW-1:0]     lhalf = DW'(lsel) + DW'(3);
  wire              last  = cfg_quad ? (bcnt == 3'd1) : (bcnt == 3'd7);
  wire [7:0]        rx_nx = cfg_quad ? {rx[3:0], io_in} : {rx[6:0], io_in[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pcnt     <= '0;
      dcnt     <= '0;
      bcnt     <= '0;
      act      <= 1'b0;
      ss_n     <= 1'b1;
      sh       <= '0;
      rx       <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      pcnt     <= (st == S_IDLE || tick) ? '0 : pcnt + HW'(1);
      case (st)
        S_IDLE: if (tx_valid) begin
          st   <= S_LEAD;
          ss_n <= 1'b0;
          sh   <= tx_data;
          bcnt <= '0;
          dcnt <= lhalf - DW'(1);
        end
        S_LEAD: if (tick) begin
          if (dcnt == '0) begin
            st  <= S_SHIFT;
            act <= 1'b1;
            rx  <= rx_nx;
          end else dcnt <= dcnt - DW'(1);
        end
        S_SHIFT: if (tick) begin
          if (act) begin
            act <= 1'b0;
            sh  <= cfg_quad ? {sh[3:0], 4'b0} : {sh[6:0], 1'b0};
            if (last) begin
              st   <= S_LAG;
              dcnt <= DW'({cfg_lag, 1'b1});
            end else bcnt <= bcnt + 3'd1;
          end else begin
            act <= 1'b1;
            rx  <= rx_nx;
          end
        end
        S_LAG: if (tick) begin
          if (dcnt == '0) begin
            st       <= S_GAP;
            ss_n     <= 1'b1;
            rx_valid <= 1'b1;
            dcnt     <= DW'({cfg_gap, 1'b1});
          end else dcnt <= dcnt - DW'(1);
        end
        S_GAP: if (tick) begin
          if (dcnt == '0) st <= S_IDLE;
          else dcnt <= dcnt - DW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tx_ready = (st == S_IDLE);
  assign rx_data  = rx;
  assign sclk     = cfg_cpol ^ act;
  assign io_out   = cfg_quad ? sh[7:4] : {3'b000, sh[7]};
  assign io_oe    = ss_n ? 4'b0000 : (cfg_quad ? (cfg_qread ? 4'b0000 : 4'b1111) : 4'b0001);

  AST_SCLK_PARKED:     assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> sclk == cfg_cpol);     // R6
  AST_READY_DESELECT:  assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> ss_n);              // R5
  AST_RXV_AT_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $rose(ss_n));       // R11
  AST_RXV_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);         // R11
  AST_OE_RELEASED:     assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> io_oe == 4'b0000);      // R10
  AST_SEL_IN_SHIFT:    assert property (@(posedge clk) disable iff (!rst_n) st == S_SHIFT |-> !ss_n);        // R7
  AST_BIT_BOUND:       assert property (@(posedge clk) disable iff (!rst_n)
                         st == S_SHIFT |-> bcnt < (cfg_quad ? 3'd2 : 3'd7) || (!cfg_quad && bcnt == 3'd7)); // R8
  AST_NO_START_BUSY:   assert property (@(posedge clk) disable iff (!rst_n)
                         (!tx_ready && ss_n) |=> ss_n || $past(st == S_IDLE));                             // R12
endmodule

// File: tb/qspi_timed_master_tb.sv
module qspi_timed_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cfg_div = 12'd8;
  logic cfg_cpol = 1'b0, cfg_quad = 1'b0, cfg_qread = 1'b0;
  logic [3:0] cfg_lead = 4'd0;
  logic [2:0] cfg_lag = 3'd0, cfg_gap = 3'd0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, sclk, ss_n;
  logic [7:0] rx_data;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in;

  always #4 clk = ~clk;

  qspi_timed_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_quad(cfg_quad), .cfg_qread(cfg_qread), .cfg_lead(cfg_lead),
    .cfg_lag(cfg_lag), .cfg_gap(cfg_gap), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .sclk(sclk), .ss_n(ss_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  int n_cmp = 0, n_bad = 0;
  bit chk_on = 1'b0;
  logic [7:0] slave_q[$];
  logic [7:0] model_q[$];

  task automatic chk(string tag, string nm, logic [7:0] a, logic [7:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, a, e, $time);
    end
  endtask

  // slave: presents response bits, advances on each trailing edge
  int sidx = 0;
  bit was_sel = 1'b0;
  logic [7:0] cur = 8'h00;
  always @(sclk or ss_n) begin
    if (ss_n) begin
      sidx = 0;
      was_sel = 1'b0;
    end else if (!was_sel) begin
      was_sel = 1'b1;
      sidx = 0;
      if (slave_q.size() > 0) cur = slave_q.pop_front();
    end else if (sclk == cfg_cpol) sidx++;
  end
  always @* begin
    if (cfg_quad) io_in = (sidx == 0) ? cur[7:4] : (sidx == 1) ? cur[3:0] : 4'h0;
    else          io_in = (sidx < 8) ? {2'b00, cur[7 - sidx], 1'b0} : 4'h0;
  end

  // behavioural timing model
  bit e_ss = 1'b1, e_act = 1'b0, e_ready = 1'b1, e_rxv = 1'b0;
  logic [7:0] e_byte = 8'h00, e_rx = 8'h00;
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (tx_valid === 1'b1 && e_ready) begin
        int h, lh, nb;
        logic [7:0] rexp;
        h  = (cfg_div / 2 < 1) ? 1 : int'(cfg_div) / 2;
        lh = ((cfg_lead > 4'd14) ? 14 : int'(cfg_lead)) + 3;
        nb = cfg_quad ? 2 : 8;
        rexp = (model_q.size() > 0) ? model_q.pop_front() : 8'h00;
        e_byte = tx_data; e_ss = 1'b0; e_ready = 1'b0;
        repeat (lh * h) @(posedge clk);
        for (int i = 0; i < nb; i++) begin
          e_act = 1'b1;
          repeat (h) @(posedge clk);
          e_act = 1'b0;
          e_byte = cfg_quad ? {e_byte[3:0], 4'b0} : {e_byte[6:0], 1'b0};
          if (i < nb - 1) repeat (h) @(posedge clk);
        end
        repeat (2 * (int'(cfg_lag) + 1) * h) @(posedge clk);
        e_ss = 1'b1; e_rxv = 1'b1; e_rx = rexp;
        repeat (2 * (int'(cfg_gap) + 1) * h) begin
          @(posedge clk);
          e_rxv = 1'b0;
        end
        e_ready = 1'b1;
      end
    end
  end

  always @(negedge clk) if (chk_on) begin
    chk("R3 R4 R5", "ss_n", {7'b0, ss_n}, {7'b0, e_ss});
    chk("R2 R6", "sclk", {7'b0, sclk}, {7'b0, cfg_cpol ^ e_act});
    chk("R7 R8 R9", "io_out", {4'b0, io_out},
        {4'b0, cfg_quad ? e_byte[7:4] : {3'b0, e_byte[7]}});
    chk("R8 R9 R10", "io_oe", {4'b0, io_oe},
        {4'b0, e_ss ? 4'b0000 : (cfg_quad ? (cfg_qread ? 4'b0000 : 4'b1111) : 4'b0001)});
    chk("R5 R12", "tx_ready", {7'b0, tx_ready}, {7'b0, e_ready});
    chk("R11", "rx_valid", {7'b0, rx_valid}, {7'b0, e_rxv});
    if (e_rxv) chk("R10 R11", "rx_data", rx_data, e_rx);
  end

  task automatic send(input logic [7:0] b, input logic [7:0] r);
    slave_q.push_back(r);
    model_q.push_back(r);
    tx_data = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!tx_ready || !ss_n) @(negedge clk);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "ss_n", {7'b0, ss_n}, 8'd1);
    chk("R1", "sclk", {7'b0, sclk}, {7'b0, cfg_cpol});
    chk("R1", "io_oe", {4'b0, io_oe}, 8'd0);
    chk("R1", "tx_ready", {7'b0, tx_ready}, 8'd1);
    chk("R1", "rx_valid", {7'b0, rx_valid}, 8'd0);
    chk_on = 1'b1;
    // R8 single line, minimum windows
    send(8'hA5, 8'h3C);
    wait_idle();
    // R5 R12 back-to-back with valid held through gap
    cfg_gap = 3'd2;
    send(8'h81, 8'hE7);
    send(8'h7E, 8'h18);
    wait_idle();
    // R3 clamp, R4, R6 idle-high clock, long windows
    cfg_cpol = 1'b1; cfg_div = 12'd6; cfg_lead = 4'd15; cfg_lag = 3'd7; cfg_gap = 3'd7;
    send(8'h5A, 8'hC3);
    wait_idle();
    cfg_lead = 4'd14;
    send(8'h01, 8'h80);
    wait_idle();
    // R9 quad write
    cfg_cpol = 1'b0; cfg_quad = 1'b1; cfg_div = 12'd4; cfg_lead = 4'd3; cfg_lag = 3'd1; cfg_gap = 3'd0;
    send(8'h96, 8'h2B);
    send(8'hF0, 8'h0F);
    wait_idle();
    // R10 quad read, minimum divisor
    cfg_qread = 1'b1; cfg_div = 12'd2; cfg_lead = 4'd5;
    send(8'h00, 8'hD4);
    wait_idle();
    // R2 odd and sub-minimum divisors
    cfg_quad = 1'b0; cfg_qread = 1'b0; cfg_div = 12'd3;
    send(8'hC9, 8'h6D);
    wait_idle();
    cfg_div = 12'd0;
    send(8'h33, 8'hAA);
    wait_idle();
    cfg_div = 12'd1; cfg_cpol = 1'b1;
    send(8'hFF, 8'h00);
    wait_idle();
    cfg_div = 12'd9; cfg_lead = 4'd7; cfg_lag = 3'd3; cfg_gap = 3'd4;
    send(8'h6B, 8'h95);
    wait_idle();
    // R2 maximum divisor, quad write
    cfg_cpol = 1'b0; cfg_quad = 1'b1; cfg_div = 12'd4080; cfg_lead = 4'd0; cfg_lag = 3'd0; cfg_gap = 3'd0;
    send(8'h4E, 8'hB1);
    wait_idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule